// File: doc/BRIEF.md
# Interrupt Mask and Status Controller

This block gathers thirty single-cycle event pulses from the sources inside a peripheral into a status register. It qualifies each pending bit with a mask and drives one combined, registered interrupt line. Software reaches it through a plain register port with four word addresses: status, mask-enable, mask-disable and mask.

The mask can only be changed by writing ones to the enable address, which clears mask bits, or to the disable address, which sets them. This avoids any read-modify-write. The mask register itself is read-only. A write to its address instead forces the status bits written as one, whatever the mask holds, so that interrupt paths can be exercised in test. Status bits are cleared by writing one to them at the status address.

The register port has no back-pressure. A write presented with `wr_en` high is taken at the next rising clock edge, and `rd_data` follows `rd_addr` combinationally. The event vector is a set of plain pulses with no handshake.

Top module: `irq_mask_status_ctl`

## Requirements
- R1: While reset is held and after it is released, the mask reads 0x3FFFFFFF, the status reads 0 and `irq` is 0.
- R2: The word addresses are: status = 0, enable = 1, disable = 2, mask = 3. Reads of the enable and disable addresses return 0.
- R3: Bits 31:30 of every read are 0, and data bits 31:30 of any write have no effect.
- R4: A write to the enable address clears each mask bit written as 1 and leaves bits written as 0 unchanged.
- R5: A write to the disable address sets each mask bit written as 1 and leaves bits written as 0 unchanged.
- R6: A write to the mask address or to the status address leaves the mask unchanged.
- R7: A write to the mask address sets each status bit written as 1, whether that bit is masked or not. Status bits written as 0 are unchanged.
- R8: A one-cycle pulse on `src_evt[i]` sets status bit i. The bit stays set until software clears it.
- R9: A write to the status address clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R10: When an event pulse and a software clear reach the same status bit in the same cycle, the bit remains set.
- R11: `irq` is a register that holds the OR of (status AND NOT mask) as it stood at the previous rising edge.
- R12: Source position 8 is unused. A pulse on `src_evt[8]` does not change status. Bit 8 still resets to 1 in the mask and can still be forced through the mask address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe, taken at the next rising edge |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word address of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| src_evt | input | 30 | Event pulses, one per source |
| irq | output | 1 | Combined interrupt, registered |

## Verification
Status and mask are updated by the rising edge that samples a write or a pulse, so they can be read back in the same cycle that follows that edge. `irq` is due one edge later still. The bench drives every input on the falling edge. It reads and samples one nanosecond later, in the low half of the clock. Each `irq` check therefore sits at a counted falling edge: one falling edge after the triggering edge for status and mask, and two for `irq`. The bench also checks that `irq` has not yet moved at the earlier of those two points.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int DATA_W = 32;

  // Word offsets of the register port
  typedef enum logic [1:0] {
    REG_STATUS  = 2'd0,
    REG_ENABLE  = 2'd1,
    REG_DISABLE = 2'd2,
    REG_MASK    = 2'd3
  } reg_sel_e;

  // Decoded write actions, at most one active per cycle
  typedef struct packed {
    logic clr_status;
    logic en_mask;
    logic dis_mask;
    logic force_status;
  } wr_strobe_t;

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_ctl_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output wr_strobe_t        strb
);

  always_comb begin
    strb = '0;
    if (wr_en) begin
      unique case (wr_addr)
        ADDR_W'(REG_STATUS):  strb.clr_status   = 1'b1;
        ADDR_W'(REG_ENABLE):  strb.en_mask      = 1'b1;
        ADDR_W'(REG_DISABLE): strb.dis_mask     = 1'b1;
        ADDR_W'(REG_MASK):    strb.force_status = 1'b1;
        default:              strb              = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_SRC = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               dis_i,
  input  logic [NUM_SRC-1:0] data_i,
  output logic [NUM_SRC-1:0] mask_o
);

  logic [NUM_SRC-1:0] mask_q;

  // A set bit means that source is disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (dis_i) begin
      mask_q <= mask_q | data_i;
    end else if (en_i) begin
      mask_q <= mask_q & ~data_i;
    end
  end

  assign mask_o = mask_q;

  // R4: enable clears exactly the ones written
  a_r4_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> ((mask_q & $past(data_i)) == '0));

  // R5: disable sets exactly the ones written
  a_r5_disable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    dis_i |=> ((mask_q & $past(data_i)) == $past(data_i)));

  // R6: no mask change without an enable or disable write
  a_r6_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !dis_i) |=> $stable(mask_q));

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int               NUM_SRC    = 30,
  parameter logic [NUM_SRC-1:0] EVT_IGNORE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic               clr_i,
  input  logic               force_i,
  input  logic [NUM_SRC-1:0] data_i,
  output logic [NUM_SRC-1:0] status_o
);

  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] evt_eff;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] clr_vec;

  assign evt_eff = src_evt_i & ~EVT_IGNORE;
  assign set_vec = evt_eff | (force_i ? data_i : '0);
  assign clr_vec = clr_i ? data_i : '0;

  // Sets are applied after clears, so an event beats a clear on the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_vec;
    end
  end

  assign status_o = status_q;

  // R8 and R10: every live event lands, clear or not
  a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_eff) |=> ((status_q & $past(evt_eff)) == $past(evt_eff)));

  // R7: test write raises the bits written as one
  a_r7_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |=> ((status_q & $past(data_i)) == $past(data_i)));

  // R9: software clear drops bits that no event refreshed
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((status_q & $past(data_i & ~src_evt_i)) == '0));

  // R12: ignored positions move only by software
  a_r12_ignored_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !force_i) |=> $stable(status_q & EVT_IGNORE));

endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
  parameter int NUM_SRC = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               irq_o
);

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |(status_i & ~mask_i);
    end
  end

  assign irq_o = irq_q;

  // R11: any unmasked pending bit raises the line one edge later
  a_r11_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_i & ~mask_i)) |=> irq_q);

  // R11: nothing unmasked pending keeps the line low one edge later
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i & ~mask_i) == '0) |=> !irq_q);

endmodule

// File: rtl/irq_mask_status_ctl.sv
module irq_mask_status_ctl
  import irq_ctl_pkg::*;
#(
  parameter int NUM_SRC        = 30,
  parameter int ADDR_W         = 2,
  parameter int UNUSED_SRC_IDX = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_SRC-1:0] src_evt,
  output logic               irq
);

  localparam logic [NUM_SRC-1:0] EVT_IGNORE = NUM_SRC'(1) << UNUSED_SRC_IDX;

  wr_strobe_t         strb;
  logic [NUM_SRC-1:0] wdata;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] status;
  logic               unused_hi;

  assign wdata     = wr_data[NUM_SRC-1:0];
  assign unused_hi = ^wr_data[DATA_W-1:NUM_SRC];

  irq_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .strb    (strb)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (strb.en_mask),
    .dis_i  (strb.dis_mask),
    .data_i (wdata),
    .mask_o (mask)
  );

  irq_status_reg #(.NUM_SRC(NUM_SRC), .EVT_IGNORE(EVT_IGNORE)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_evt_i (src_evt),
    .clr_i     (strb.clr_status),
    .force_i   (strb.force_status),
    .data_i    (wdata),
    .status_o  (status)
  );

  irq_out_reg #(.NUM_SRC(NUM_SRC)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status),
    .mask_i   (mask),
    .irq_o    (irq)
  );

  // Read mux; unused upper bits and the write-only addresses return zero
  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(REG_STATUS)) begin
      rd_data[NUM_SRC-1:0] = status;
    end else if (rd_addr == ADDR_W'(REG_MASK)) begin
      rd_data[NUM_SRC-1:0] = mask;
    end
  end

  // R6: a write to the mask address never changes the mask
  a_r6_mask_addr_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(REG_MASK)) |=> $stable(mask));

endmodule

// File: tb/tb_irq_mask_status_ctl.sv
`timescale 1ns/1ps
module tb_irq_mask_status_ctl;

  localparam int NS = 30;
  localparam logic [1:0] A_STAT = 2'd0, A_EN = 2'd1, A_DIS = 2'd2, A_MASK = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [NS-1:0] src_evt = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_mask_status_ctl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .src_evt(src_evt), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Present one write; returns at the falling edge after it was taken
  task automatic do_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // One-cycle event pulse; returns at the falling edge after it was taken
  task automatic pulse(input logic [NS-1:0] v);
    @(negedge clk);
    src_evt = v;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rd(A_MASK, d); chk("R1 mask in reset", d, 32'h3FFF_FFFF);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_MASK, d); chk("R1 mask after reset", d, 32'h3FFF_FFFF);
    rd(A_STAT, d); chk("R1 status after reset", d, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(A_EN, d);   chk("R2 enable reads zero", d, 32'h0);
    rd(A_DIS, d);  chk("R2 disable reads zero", d, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    do_wr(A_EN, 32'h0000_0005);
    rd(A_MASK, d); chk("R4 enable clears bits 0 and 2", d, 32'h3FFF_FFFA);
    do_wr(A_EN, 32'hC000_0000);
    rd(A_MASK, d); chk("R3 reserved write bits no effect", d, 32'h3FFF_FFFA);
    chk("R3 reserved read bits zero", {30'b0, d[31:30]}, 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    do_wr(A_DIS, 32'h0000_0001);
    rd(A_MASK, d); chk("R5 disable sets bit 0 only", d, 32'h3FFF_FFFB);
  endtask

  task automatic t_force();
    logic [31:0] d;
    do_wr(A_MASK, 32'h0000_0010);
    rd(A_MASK, d); chk("R6 mask address write leaves mask", d, 32'h3FFF_FFFB);
    rd(A_STAT, d); chk("R7 forced masked bit 4", d, 32'h0000_0010);
    @(negedge clk);
    chk("R11 masked pending gives no irq", {31'b0, irq}, 32'h0);
    do_wr(A_STAT, 32'h0000_0010);
    rd(A_STAT, d); chk("R9 clear bit 4", d, 32'h0);
    rd(A_MASK, d); chk("R6 status write leaves mask", d, 32'h3FFF_FFFB);
  endtask

  task automatic t_event();
    logic [31:0] d;
    pulse(NS'(32'h0000_0004));
    rd(A_STAT, d); chk("R8 event sets bit 2", d, 32'h0000_0004);
    chk("R11 irq not before one edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R11 irq one edge later", {31'b0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    rd(A_STAT, d); chk("R8 status held", d, 32'h0000_0004);
    do_wr(A_STAT, 32'h0000_0001);
    rd(A_STAT, d); chk("R9 zeros leave bit 2", d, 32'h0000_0004);
  endtask

  task automatic t_race();
    logic [31:0] d;
    @(negedge clk);
    src_evt = NS'(32'h0000_0004);
    wr_en = 1'b1; wr_addr = A_STAT; wr_data = 32'h0000_0004;
    @(negedge clk);
    src_evt = '0; wr_en = 1'b0; wr_data = '0;
    rd(A_STAT, d); chk("R10 event wins over clear", d, 32'h0000_0004);
    do_wr(A_STAT, 32'h0000_0004);
    rd(A_STAT, d); chk("R9 clear bit 2", d, 32'h0);
    @(negedge clk);
    chk("R11 irq falls after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_unused();
    logic [31:0] d;
    do_wr(A_EN, 32'h0000_0100);
    pulse(NS'(32'h0000_0100));
    rd(A_STAT, d); chk("R12 event on bit 8 ignored", d, 32'h0);
    @(negedge clk);
    chk("R12 no irq from bit 8 event", {31'b0, irq}, 32'h0);
    do_wr(A_MASK, 32'h0000_0100);
    rd(A_STAT, d); chk("R12 bit 8 forced", d, 32'h0000_0100);
    @(negedge clk);
    chk("R11 irq from forced bit 8", {31'b0, irq}, 32'h1);
    do_wr(A_DIS, 32'h0000_0100);
    chk("R11 irq still high one edge after masking", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R11 irq low after masking", {31'b0, irq}, 32'h0);
    rd(A_MASK, d); chk("R5 bit 8 masked again", d, 32'h3FFF_FFFB);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_enable();
    t_disable();
    t_force();
    t_event();
    t_race();
    t_unused();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule